// File: doc/BRIEF.md
# Display Mode Register Block

This block is the device-side register file of a linear-framebuffer display adapter. It keeps the mode state a scanout engine needs: horizontal and vertical resolution, pixel depth, an enable word, a bank number, the virtual canvas size and the panning offsets. It also reports a fixed identity word and the size of the video memory. Every decoded field is driven straight to the scanout engine as a port.

Software reaches the same register set in two ways. The first is a 16-bit I/O bus, through a pointer port and a data port: software first writes the register number to the pointer, then reads or writes the data port. The second is a memory-mapped window, where each register appears as a 16-bit word. The window also carries a small extension area. Its first word gives the size of that area. Its second word selects whether pixels are stored big-endian or little-endian, and it changes only when one of two magic values is written.

All register state is flopped. Read data from either bus is also registered and appears one cycle after the read strobe.

Top module: `dm_regs`

## Requirements
- R1: On the I/O bus, address 0x01CE is the pointer port: a write stores the register number, and a read returns it. Address 0x01CF is the data port, which reads or writes the register the pointer selects. A read of any other I/O address returns 0, and a write to any other I/O address changes nothing.
- R2: The register numbers are 1 X resolution, 2 Y resolution, 3 bits per pixel, 5 bank, 6 virtual width, 7 virtual height, 8 X offset and 9 Y offset. An accepted write shows on the matching output port from the cycle after the write strobe.
- R3: In the memory window, register n is the 16-bit word at byte offset 0x500 + 2·n. It reads back in bits 15:0 with bits 31:16 at zero. Both buses act on one shared set of registers.
- R4: Register 0 reads 0xB0C0 plus VERSION (0xB0C5 by default), and writes to it are ignored.
- R5: Register 0xA reads MEM_64K, the memory size in 64 KiB units (256 by default), and writes to it are ignored.
- R6: Register 4, the enable word, keeps only bit 0 (display on), bit 1 (capability query), bit 5 (8-bit palette), bit 6 (linear framebuffer) and bit 7 (keep memory contents). All other bits read 0. Bits 0, 5, 6 and 7 drive en_o, dac8_o, lfb_o and noclr_o.
- R7: While en_o is 1, writes to registers 1, 2, 3, 5 and 7 are ignored. Writes to registers 6, 8 and 9 still take effect.
- R8: While enable bit 1 is set, registers 1, 2 and 3 read back MAX_X, MAX_Y and MAX_BPP (2560, 1600 and 32 by default). The output ports keep the programmed values.
- R9: A register number above 0xA reads 0 on both buses. A window read outside the register area and outside the extension words returns 0xFFFFFFFF.
- R10: Window offset 0x600 reads EXT_SIZE, the size of the extension area in bytes (8 by default).
- R11: Window offset 0x604 exists when EXT_SIZE is at least 8. Writing 0xBEBEBEBE there sets big_endian_o to 1, and writing 0x1E1E1E1E sets it to 0. Writing any other value leaves it unchanged. A read returns the magic value in force, and after reset that value is 0x1E1E1E1E.
- R12: When both buses write a register in the same cycle, the I/O write takes effect and the window write is dropped.
- R13: Read data on each bus appears in the cycle after the read strobe. It holds its value until the next read on that bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 16 | I/O bus address |
| io_wr | input | 1 | I/O write strobe |
| io_rd | input | 1 | I/O read strobe |
| io_wdata | input | 16 | I/O write data |
| io_rdata | output | 16 | I/O read data, registered |
| mm_addr | input | AW | Window byte offset, AW = clog2(WIN_BYTES) |
| mm_wr | input | 1 | Window write strobe |
| mm_rd | input | 1 | Window read strobe |
| mm_wdata | input | 32 | Window write data |
| mm_rdata | output | 32 | Window read data, registered |
| xres_o | output | 16 | X resolution |
| yres_o | output | 16 | Y resolution |
| bpp_o | output | 16 | Bits per pixel |
| bank_o | output | 16 | Bank number |
| vwidth_o | output | 16 | Virtual width |
| vheight_o | output | 16 | Virtual height |
| xoff_o | output | 16 | X offset |
| yoff_o | output | 16 | Y offset |
| en_o | output | 1 | Display on |
| lfb_o | output | 1 | Linear framebuffer on |
| dac8_o | output | 1 | 8-bit palette |
| noclr_o | output | 1 | Keep memory contents |
| big_endian_o | output | 1 | Pixel byte order is big-endian |

## Verification
A write is captured at the clock edge where its strobe is high. The output ports show the new value one cycle after the strobe, because each field passes through exactly one register. A read strobe loads the read data register at that same edge, so the value is due one cycle after the strobe and stays until the next read on that bus.

The bench drives strobes on falling edges and samples outputs on the next falling edge, which lies half a cycle after the capturing edge. Each ignored write, whether it is locked, read-only or uses a non-magic value, is followed by a read-back or an output sample before the next stimulus.

// File: rtl/dm_pkg.sv
package dm_pkg;
  // register numbers: fixed by the software programming model
  localparam logic [15:0] IX_ID   = 16'd0;
  localparam logic [15:0] IX_XRES = 16'd1;
  localparam logic [15:0] IX_YRES = 16'd2;
  localparam logic [15:0] IX_BPP  = 16'd3;
  localparam logic [15:0] IX_EN   = 16'd4;
  localparam logic [15:0] IX_BANK = 16'd5;
  localparam logic [15:0] IX_VWID = 16'd6;
  localparam logic [15:0] IX_VHGT = 16'd7;
  localparam logic [15:0] IX_XOFF = 16'd8;
  localparam logic [15:0] IX_YOFF = 16'd9;
  localparam logic [15:0] IX_MEM  = 16'd10;

  localparam int EN_ON    = 0;
  localparam int EN_CAPS  = 1;
  localparam int EN_DAC8  = 5;
  localparam int EN_LFB   = 6;
  localparam int EN_NOCLR = 7;
  localparam logic [7:0] EN_KEEP = 8'hE3;

  localparam logic [31:0] MAGIC_BIG = 32'hBEBEBEBE;
  localparam logic [31:0] MAGIC_LIT = 32'h1E1E1E1E;

  typedef struct packed {
    logic [15:0] xres;
    logic [15:0] yres;
    logic [15:0] bpp;
    logic [7:0]  en;
    logic [15:0] bank;
    logic [15:0] vwid;
    logic [15:0] vhgt;
    logic [15:0] xoff;
    logic [15:0] yoff;
  } mode_t;
endpackage

// File: rtl/dm_bank.sv
module dm_bank
  import dm_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [15:0] wr_ix,
  input  logic [15:0] wr_data,
  output mode_t       st
);
  mode_t nxt;
  logic  unlocked;

  assign unlocked = ~st.en[EN_ON];

  always_comb begin
    nxt = st;
    if (wr_en) begin
      case (wr_ix)
        IX_XRES: if (unlocked) nxt.xres = wr_data;
        IX_YRES: if (unlocked) nxt.yres = wr_data;
        IX_BPP:  if (unlocked) nxt.bpp  = wr_data;
        IX_BANK: if (unlocked) nxt.bank = wr_data;
        IX_VHGT: if (unlocked) nxt.vhgt = wr_data;
        IX_EN:   nxt.en   = wr_data[7:0] & EN_KEEP;
        IX_VWID: nxt.vwid = wr_data;
        IX_XOFF: nxt.xoff = wr_data;
        IX_YOFF: nxt.yoff = wr_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= '0;
    else if (wr_en) st <= nxt;
  end
endmodule

// File: rtl/dm_endian.sv
module dm_endian
  import dm_pkg::*;
#(
  parameter int EXT_SIZE = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr,
  input  logic [31:0] wdata,
  output logic        big,
  output logic [31:0] magic
);
  generate
    if (EXT_SIZE >= 8) begin : g_word
      logic big_nxt, upd;
      always_comb begin
        upd     = wr && (wdata == MAGIC_BIG || wdata == MAGIC_LIT);
        big_nxt = (wdata == MAGIC_BIG);
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) big <= 1'b0;
        else if (upd) big <= big_nxt;
      end
    end else begin : g_none
      logic unused_in;
      assign unused_in = ^{clk, rst_n, wr, wdata};
      assign big = 1'b0;
    end
  endgenerate

  assign magic = big ? MAGIC_BIG : MAGIC_LIT;
endmodule

// File: rtl/dm_regs.sv
module dm_regs
  import dm_pkg::*;
#(
  parameter int VERSION   = 5,
  parameter int MEM_64K   = 256,
  parameter int EXT_SIZE  = 8,
  parameter int WIN_BYTES = 4096,
  parameter int MAX_X     = 2560,
  parameter int MAX_Y     = 1600,
  parameter int MAX_BPP   = 32,
  parameter int AW        = $clog2(WIN_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [15:0]   io_addr,
  input  logic          io_wr,
  input  logic          io_rd,
  input  logic [15:0]   io_wdata,
  output logic [15:0]   io_rdata,
  input  logic [AW-1:0] mm_addr,
  input  logic          mm_wr,
  input  logic          mm_rd,
  input  logic [31:0]   mm_wdata,
  output logic [31:0]   mm_rdata,
  output logic [15:0]   xres_o,
  output logic [15:0]   yres_o,
  output logic [15:0]   bpp_o,
  output logic [15:0]   bank_o,
  output logic [15:0]   vwidth_o,
  output logic [15:0]   vheight_o,
  output logic [15:0]   xoff_o,
  output logic [15:0]   yoff_o,
  output logic          en_o,
  output logic          lfb_o,
  output logic          dac8_o,
  output logic          noclr_o,
  output logic          big_endian_o
);
  localparam logic [15:0]   IO_PTR   = 16'h01CE;
  localparam logic [15:0]   IO_DAT   = 16'h01CF;
  localparam logic [AW-1:0] A_EXTSZ  = AW'('h600);
  localparam logic [AW-1:0] A_ORDER  = AW'('h604);
  localparam logic [AW-9:0] BANK_PG  = (AW-8)'(5);
  localparam bit            HAS_ORD  = (EXT_SIZE >= 8);
  localparam logic [15:0]   ID_WORD  = 16'hB0C0 | 16'(VERSION);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign srst_n = rs_q[1];

  mode_t       st;
  logic [15:0] ptr_q, ptr_d;
  logic        ptr_we;
  logic        io_dw, mm_in_bank, mm_bw, ord_we;
  logic [15:0] mm_ix, bk_ix, bk_data;
  logic [31:0] magic;
  logic [15:0] io_rd_d;
  logic [31:0] mm_rd_d;

  function automatic logic [15:0] rd_reg(input mode_t s, input logic [15:0] ix);
    logic caps;
    caps = s.en[EN_CAPS];
    case (ix)
      IX_ID:   rd_reg = ID_WORD;
      IX_XRES: rd_reg = caps ? 16'(MAX_X)   : s.xres;
      IX_YRES: rd_reg = caps ? 16'(MAX_Y)   : s.yres;
      IX_BPP:  rd_reg = caps ? 16'(MAX_BPP) : s.bpp;
      IX_EN:   rd_reg = {8'h00, s.en};
      IX_BANK: rd_reg = s.bank;
      IX_VWID: rd_reg = s.vwid;
      IX_VHGT: rd_reg = s.vhgt;
      IX_XOFF: rd_reg = s.xoff;
      IX_YOFF: rd_reg = s.yoff;
      IX_MEM:  rd_reg = 16'(MEM_64K);
      default: rd_reg = 16'h0000;
    endcase
  endfunction

  // decode and write arbitration (I/O bus first)
  always_comb begin
    ptr_we     = io_wr && (io_addr == IO_PTR);
    ptr_d      = io_wdata;
    io_dw      = io_wr && (io_addr == IO_DAT);
    mm_in_bank = (mm_addr[AW-1:8] == BANK_PG);
    mm_ix      = {9'd0, mm_addr[7:1]};
    mm_bw      = mm_wr && mm_in_bank && !io_dw;
    bk_ix      = io_dw ? ptr_q : mm_ix;
    bk_data    = io_dw ? io_wdata : mm_wdata[15:0];
    ord_we     = mm_wr && HAS_ORD && (mm_addr == A_ORDER);
  end

  always_comb begin
    if (io_addr == IO_PTR)      io_rd_d = ptr_q;
    else if (io_addr == IO_DAT) io_rd_d = rd_reg(st, ptr_q);
    else                        io_rd_d = 16'h0000;

    if (mm_in_bank)                        mm_rd_d = {16'h0000, rd_reg(st, mm_ix)};
    else if (mm_addr == A_EXTSZ)           mm_rd_d = 32'(EXT_SIZE);
    else if (HAS_ORD && mm_addr == A_ORDER) mm_rd_d = magic;
    else                                   mm_rd_d = 32'hFFFF_FFFF;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      ptr_q    <= 16'h0000;
      io_rdata <= 16'h0000;
      mm_rdata <= 32'h0000_0000;
    end else begin
      if (ptr_we) ptr_q    <= ptr_d;
      if (io_rd)  io_rdata <= io_rd_d;
      if (mm_rd)  mm_rdata <= mm_rd_d;
    end
  end

  dm_bank u_bank (
    .clk     (clk),
    .rst_n   (srst_n),
    .wr_en   (io_dw | mm_bw),
    .wr_ix   (bk_ix),
    .wr_data (bk_data),
    .st      (st)
  );

  dm_endian #(.EXT_SIZE(EXT_SIZE)) u_order (
    .clk   (clk),
    .rst_n (srst_n),
    .wr    (ord_we),
    .wdata (mm_wdata),
    .big   (big_endian_o),
    .magic (magic)
  );

  assign xres_o    = st.xres;
  assign yres_o    = st.yres;
  assign bpp_o     = st.bpp;
  assign bank_o    = st.bank;
  assign vwidth_o  = st.vwid;
  assign vheight_o = st.vhgt;
  assign xoff_o    = st.xoff;
  assign yoff_o    = st.yoff;
  assign en_o      = st.en[EN_ON];
  assign lfb_o     = st.en[EN_LFB];
  assign dac8_o    = st.en[EN_DAC8];
  assign noclr_o   = st.en[EN_NOCLR];
endmodule

// File: rtl/dm_regs_chk.sv
module dm_regs_chk #(
  parameter int AW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          io_rd,
  input logic [15:0]   io_rdata,
  input logic [AW-1:0] mm_addr,
  input logic          mm_wr,
  input logic          mm_rd,
  input logic [31:0]   mm_rdata,
  input logic [15:0]   xres_o,
  input logic [15:0]   yres_o,
  input logic [15:0]   bpp_o,
  input logic [15:0]   vheight_o,
  input logic          en_o,
  input logic          big_endian_o
);
  p_lock_xres_r7: assert property (@(posedge clk) disable iff (!rst_n)
    en_o |=> $stable(xres_o));
  p_lock_yres_r7: assert property (@(posedge clk) disable iff (!rst_n)
    en_o |=> $stable(yres_o));
  p_lock_bpp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    en_o |=> $stable(bpp_o));
  p_lock_vhgt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    en_o |=> $stable(vheight_o));
  p_order_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !mm_wr |=> $stable(big_endian_o));
  p_ident_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mm_rd && mm_addr == AW'('h500)) |=> (mm_rdata[31:4] == 28'h0000B0C));
  p_unmapped_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mm_rd && mm_addr == AW'('h000)) |=> (mm_rdata == 32'hFFFF_FFFF));
  p_io_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !io_rd |=> $stable(io_rdata));
  p_mm_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !mm_rd |=> $stable(mm_rdata));
endmodule

bind dm_regs dm_regs_chk #(.AW(AW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .io_rd        (io_rd),
  .io_rdata     (io_rdata),
  .mm_addr      (mm_addr),
  .mm_wr        (mm_wr),
  .mm_rd        (mm_rd),
  .mm_rdata     (mm_rdata),
  .xres_o       (xres_o),
  .yres_o       (yres_o),
  .bpp_o        (bpp_o),
  .vheight_o    (vheight_o),
  .en_o         (en_o),
  .big_endian_o (big_endian_o)
);

// File: tb/tb_dm_regs.sv
module tb_dm_regs;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 12;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [15:0]   io_addr, io_wdata, io_rdata;
  logic          io_wr, io_rd;
  logic [AW-1:0] mm_addr;
  logic          mm_wr, mm_rd;
  logic [31:0]   mm_wdata, mm_rdata;
  logic [15:0]   xres_o, yres_o, bpp_o, bank_o, vwidth_o, vheight_o, xoff_o, yoff_o;
  logic          en_o, lfb_o, dac8_o, noclr_o, big_endian_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dm_regs dut (
    .clk(clk), .rst_n(rst_n),
    .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .mm_addr(mm_addr), .mm_wr(mm_wr), .mm_rd(mm_rd), .mm_wdata(mm_wdata), .mm_rdata(mm_rdata),
    .xres_o(xres_o), .yres_o(yres_o), .bpp_o(bpp_o), .bank_o(bank_o),
    .vwidth_o(vwidth_o), .vheight_o(vheight_o), .xoff_o(xoff_o), .yoff_o(yoff_o),
    .en_o(en_o), .lfb_o(lfb_o), .dac8_o(dac8_o), .noclr_o(noclr_o),
    .big_endian_o(big_endian_o)
  );

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // strobes go high on a falling edge, are captured at the next rising edge,
  // and results are sampled on the falling edge after that
  task automatic io_write(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk); io_wr = 1'b0;
  endtask

  task automatic io_read(input logic [15:0] a, output logic [15:0] d);
    @(negedge clk); io_addr = a; io_rd = 1'b1;
    @(negedge clk); io_rd = 1'b0; d = io_rdata;
  endtask

  task automatic reg_write(input logic [15:0] ix, input logic [15:0] d);
    io_write(16'h01CE, ix);
    io_write(16'h01CF, d);
  endtask

  task automatic reg_read(input logic [15:0] ix, output logic [15:0] d);
    io_write(16'h01CE, ix);
    io_read(16'h01CF, d);
  endtask

  task automatic mm_write(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk); mm_addr = a; mm_wdata = d; mm_wr = 1'b1;
    @(negedge clk); mm_wr = 1'b0;
  endtask

  task automatic mm_read(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk); mm_addr = a; mm_rd = 1'b1;
    @(negedge clk); mm_rd = 1'b0; d = mm_rdata;
  endtask

  task automatic t_reset();
    logic [15:0] r;
    check("R2", "xres after reset", 32'(xres_o), 32'h0);
    check("R6", "en after reset", 32'(en_o), 32'h0);
    check("R11", "order after reset", 32'(big_endian_o), 32'h0);
    reg_read(16'd0, r);
    check("R4", "identity", 32'(r), 32'hB0C5);
    io_read(16'h01CE, r);
    check("R1", "pointer readback", 32'(r), 32'h0);
  endtask

  task automatic t_program();
    logic [15:0] r;
    logic [31:0] w;
    reg_write(16'd1, 16'd1024);
    check("R2", "xres port", 32'(xres_o), 32'd1024);
    mm_write(AW'('h504), 32'hABCD_0300);
    check("R3", "yres from window", 32'(yres_o), 32'h0300);
    reg_read(16'd2, r);
    check("R3", "yres read over io", 32'(r), 32'h0300);
    mm_read(AW'('h502), w);
    check("R3", "xres read over window", w, 32'd1024);
    reg_write(16'd3, 16'd32);
    reg_write(16'd5, 16'd3);
    reg_write(16'd7, 16'd600);
    check("R2", "bpp port", 32'(bpp_o), 32'd32);
    check("R2", "bank port", 32'(bank_o), 32'd3);
    check("R2", "vheight port", 32'(vheight_o), 32'd600);
    io_write(16'h0100, 16'h1234);
    io_read(16'h01CE, r);
    check("R1", "stray io write leaves pointer", 32'(r), 32'd7);
    check("R1", "stray io write leaves regs", 32'(vheight_o), 32'd600);
    io_read(16'h03C0, r);
    check("R1", "stray io read", 32'(r), 32'h0);
  endtask

  task automatic t_readonly();
    logic [15:0] r;
    reg_read(16'd10, r);
    check("R5", "memory size", 32'(r), 32'd256);
    reg_write(16'd10, 16'd5);
    reg_read(16'd10, r);
    check("R5", "memory size after write", 32'(r), 32'd256);
    reg_write(16'd0, 16'h1111);
    reg_read(16'd0, r);
    check("R4", "identity after write", 32'(r), 32'hB0C5);
  endtask

  task automatic t_enable_lock();
    logic [15:0] r;
    reg_write(16'd4, 16'hFFFF);
    reg_read(16'd4, r);
    check("R6", "enable keeps bits", 32'(r), 32'h00E3);
    check("R6", "en/lfb/dac8/noclr", {28'h0, en_o, lfb_o, dac8_o, noclr_o}, 32'hF);
    reg_read(16'd1, r);
    check("R8", "caps xres", 32'(r), 32'd2560);
    reg_read(16'd2, r);
    check("R8", "caps yres", 32'(r), 32'd1600);
    reg_read(16'd3, r);
    check("R8", "caps bpp", 32'(r), 32'd32);
    check("R8", "xres port under caps", 32'(xres_o), 32'd1024);
    reg_write(16'd1, 16'd640);
    check("R7", "xres locked", 32'(xres_o), 32'd1024);
    mm_write(AW'('h50E), 32'd999);
    check("R7", "vheight locked", 32'(vheight_o), 32'd600);
    reg_write(16'd5, 16'd9);
    check("R7", "bank locked", 32'(bank_o), 32'd3);
    reg_write(16'd6, 16'd2048);
    check("R7", "vwidth open", 32'(vwidth_o), 32'd2048);
    reg_write(16'd8, 16'd7);
    reg_write(16'd9, 16'd13);
    check("R7", "offsets open", {xoff_o, yoff_o}, {16'd7, 16'd13});
    reg_write(16'd4, 16'h0041);
    reg_read(16'd1, r);
    check("R8", "caps cleared xres", 32'(r), 32'd1024);
    reg_write(16'd4, 16'h0000);
    reg_write(16'd1, 16'd800);
    check("R7", "xres after unlock", 32'(xres_o), 32'd800);
  endtask

  task automatic t_unmapped();
    logic [15:0] r;
    logic [31:0] w;
    reg_read(16'h000B, r);
    check("R9", "io reg 0xB", 32'(r), 32'h0);
    mm_read(AW'('h516), w);
    check("R9", "window reg 0xB", w, 32'h0);
    mm_read(AW'('h000), w);
    check("R9", "window 0x000", w, 32'hFFFF_FFFF);
    mm_read(AW'('h700), w);
    check("R9", "window 0x700", w, 32'hFFFF_FFFF);
  endtask

  task automatic t_order();
    logic [31:0] w;
    mm_read(AW'('h600), w);
    check("R10", "extension size", w, 32'd8);
    mm_read(AW'('h604), w);
    check("R11", "order word reset", w, 32'h1E1E1E1E);
    mm_write(AW'('h604), 32'hBEBEBEBE);
    check("R11", "big selected", 32'(big_endian_o), 32'h1);
    mm_write(AW'('h604), 32'h1234_5678);
    check("R11", "other value ignored", 32'(big_endian_o), 32'h1);
    mm_read(AW'('h604), w);
    check("R11", "order word big", w, 32'hBEBEBEBE);
    mm_write(AW'('h604), 32'h1E1E1E1E);
    check("R11", "little selected", 32'(big_endian_o), 32'h0);
  endtask

  task automatic t_collide_latency();
    logic [15:0] r;
    io_write(16'h01CE, 16'd8);
    @(negedge clk);
    io_addr = 16'h01CF; io_wdata = 16'd11; io_wr = 1'b1;
    mm_addr = AW'('h510); mm_wdata = 32'd22; mm_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0; mm_wr = 1'b0;
    check("R12", "io wins collision", 32'(xoff_o), 32'd11);
    @(negedge clk); io_addr = 16'h01CF; io_rd = 1'b1;
    @(negedge clk); io_rd = 1'b0;
    check("R13", "read due next cycle", 32'(io_rdata), 32'd11);
    reg_write(16'd8, 16'd55);
    io_write(16'h01CE, 16'd0);
    check("R13", "read data held", 32'(io_rdata), 32'd11);
    io_read(16'h01CE, r);
    check("R1", "pointer written", 32'(r), 32'd0);
  endtask

  initial begin
    rst_n = 1'b0;
    io_addr = '0; io_wdata = '0; io_wr = 1'b0; io_rd = 1'b0;
    mm_addr = '0; mm_wdata = '0; mm_wr = 1'b0; mm_rd = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_program();
    t_readonly();
    t_enable_lock();
    t_unmapped();
    t_order();
    t_collide_latency();
    done = 1;
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
    end
  end
endmodule